// File: doc/BRIEF.md
# Serial DAC Register Bank with Per-Channel Load Masking

This block holds the digital side of an eight-channel converter front end. A host shifts 32-bit command frames in over a three-wire serial link, most significant bit first. Each frame can load a staging ("input") register, load a staging register and then release every channel at once, or program a mask. Each channel also has an output ("DAC") register, and the eight output registers drive the converter cores.

The host can move staged values into the output registers in three ways. A channel can update at the end of its own frame. All pin-controlled channels update together on a falling edge of an active-low load pin. A single command can release every channel. An 8-bit mask picks, per channel, between pin-controlled loading and loading at frame end. A channel whose mask bit is set acts as if the load pin were held low. The host can therefore move a chosen group of channels in lock-step while the other channels keep tracking their writes. All serial and pin inputs are sampled into the system clock domain through multi-flop synchronizers.

Top module: `ser_dac_bank`

## Requirements
- R1: After reset every output register, every staging register and every mask bit is 0.
- R2: Frame format and framing:
  - A frame is taken while `sync_n` is low, one bit per falling edge of `sclk`, MSB first.
  - Frame bits 27..24 hold the command, bits 23..20 the address, and bits 19..8 the 12-bit channel value.
  - Bits 31..28 have no effect.
- R3: Command 0000 loads staging registers only:
  - Address 0..7 selects channels A..H, and address 1111 selects every channel.
  - Any other address writes no channel.
- R4: A channel with mask bit 0 keeps its output when written while `ldac_n` is high. Each falling edge of `ldac_n` copies its staging register to its output register.
- R5: Command 0110 loads the mask from frame bits 7..0, with bit 0 for channel A through bit 7 for channel H. Its address and data fields have no effect.
- R6: A channel with mask bit 1 copies a new write to its output when the frame completes, whatever the state of `ldac_n`.
- R7: While `ldac_n` is held low, every written channel updates its output when the frame completes, whatever its mask bit.
- R8: Command 0011 writes the addressed staging register(s) and then copies every staging register to its output register.
- R9: If `sync_n` rises before the 32nd falling `sclk` edge, the partial frame is discarded and no register changes.
- R10: Falling `sclk` edges after the 32nd, while `sync_n` stays low, are ignored.
- R11: Command codes other than 0000, 0011 and 0110 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high, data taken on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load pin for pin-controlled channels |
| dac_out | output | CH_CNT*DATA_W | Output registers, channel A in the lowest DATA_W bits |

## Verification
The assertions assume that `sclk`, `sync_n`, `sdin` and `ldac_n` change slowly compared with the system clock, so each level lasts several clocks after synchronization and no edge is lost or merged. They also assume that `sdin` is stable before the falling `sclk` edge that samples it. The stimulus holds each serial half period and each pin level for four system clocks or more. It changes `sdin` and `sync_n` only while `sclk` is high, and it changes `ldac_n` only between frames. The reference model is compared with the outputs only once the synchronizer and decode latency after each stimulus has elapsed.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
   // frame geometry; positions are fixed by the serial format
   localparam int FRAME_W  = 32;
   localparam int CMD_LSB  = 24;
   localparam int CMD_W    = 4;
   localparam int ADR_LSB  = 20;
   localparam int ADR_W    = 4;
   localparam int DAT_MSB  = 19;
   localparam int DAT_MAXW = 12;
   localparam int MASK_W   = 8;
   // only the bits below the ignored top nibble are kept
   localparam int KEEP_W   = CMD_LSB + CMD_W;

   typedef enum logic [CMD_W-1:0] {
      CMD_WR_IN      = 4'b0000,
      CMD_WR_UPD_ALL = 4'b0011,
      CMD_LD_MASK    = 4'b0110
   } cmd_e;

   localparam logic [ADR_W-1:0] ADR_ALL = 4'hF;
endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("dacbank_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dacbank_fall.sv
module dacbank_fall #(
   parameter logic RST_VAL = 1'b1,
   parameter bit   FALLING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);
   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= RST_VAL;
      else        lvl_d <= lvl;
   end

   if (FALLING) begin : g_fall
      assign pulse = lvl_d & ~lvl;
   end else begin : g_rise
      assign pulse = ~lvl_d & lvl;
   end
endmodule

// File: rtl/dacbank_shift.sv
module dacbank_shift
   import dacbank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              bit_stb,
   input  logic              bit_val,
   output logic              frame_vld,
   output logic [KEEP_W-1:0] frame_word
);
   localparam int CNT_W = $clog2(FRAME_W + 1);

   logic [KEEP_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic [KEEP_W-1:0] shnext;

   assign shnext = {shreg[KEEP_W-2:0], bit_val};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         cnt        <= '0;
         frame_vld  <= 1'b0;
         frame_word <= '0;
      end else begin
         frame_vld <= 1'b0;
         if (!sel) begin
            cnt <= '0;
         end else if (bit_stb && (cnt < CNT_W'(FRAME_W))) begin
            shreg <= shnext;
            cnt   <= cnt + 1'b1;
            if (cnt == CNT_W'(FRAME_W - 1)) begin
               frame_vld  <= 1'b1;
               frame_word <= shnext;
            end
         end
      end
   end
endmodule

// File: rtl/dacbank_decode.sv
module dacbank_decode
   import dacbank_pkg::*;
#(
   parameter int CH_CNT = 8,
   parameter int DATA_W = 12
) (
   input  logic              frame_vld,
   input  logic [KEEP_W-1:0] frame_word,
   output logic [CH_CNT-1:0] wr_sel,
   output logic [DATA_W-1:0] wr_data,
   output logic              upd_all,
   output logic              mask_wr,
   output logic [CH_CNT-1:0] mask_data
);
   logic [CMD_W-1:0] cmd;
   logic [ADR_W-1:0] adr;
   logic             is_wr;

   assign cmd       = frame_word[CMD_LSB +: CMD_W];
   assign adr       = frame_word[ADR_LSB +: ADR_W];
   assign wr_data   = frame_word[DAT_MSB -: DATA_W];
   assign mask_data = frame_word[CH_CNT-1:0];

   assign is_wr   = frame_vld && ((cmd == CMD_WR_IN) || (cmd == CMD_WR_UPD_ALL));
   assign upd_all = frame_vld && (cmd == CMD_WR_UPD_ALL);
   assign mask_wr = frame_vld && (cmd == CMD_LD_MASK);

   for (genvar ch = 0; ch < CH_CNT; ch++) begin : g_sel
      assign wr_sel[ch] = is_wr && ((adr == ADR_W'(ch)) || (adr == ADR_ALL));
   end
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              upd_on_wr,
   input  logic              upd_all,
   input  logic              upd_pin,
   output logic [DATA_W-1:0] in_val,
   output logic [DATA_W-1:0] dac_val
);
   logic [DATA_W-1:0] in_next;
   logic              load;

   // a same-cycle write is forwarded so an update never takes a stale value
   assign in_next = wr ? wr_data : in_val;
   assign load    = (wr && upd_on_wr) || upd_all || upd_pin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_val  <= '0;
         dac_val <= '0;
      end else begin
         in_val <= in_next;
         if (load) dac_val <= in_next;
      end
   end
endmodule

// File: rtl/ser_dac_bank.sv
module ser_dac_bank
   import dacbank_pkg::*;
#(
   parameter int CH_CNT      = 8,
   parameter int DATA_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sclk,
   input  logic                     sync_n,
   input  logic                     sdin,
   input  logic                     ldac_n,
   output logic [CH_CNT*DATA_W-1:0] dac_out
);
   if (CH_CNT < 1 || CH_CNT > MASK_W) begin : g_bad_ch
      $error("ser_dac_bank: CH_CNT out of range");
   end
   if (DATA_W < 1 || DATA_W > DAT_MAXW) begin : g_bad_dw
      $error("ser_dac_bank: DATA_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ser_dac_bank: SYNC_STAGES below 2");
   end

   logic sclk_q, sclk_fall, sync_q, sdin_q, ldac_q, ld_pulse;
   logic              frame_vld;
   logic [KEEP_W-1:0] frame_word;
   logic [CH_CNT-1:0] wr_sel, mask_data, mask;
   logic [DATA_W-1:0] wr_data;
   logic              upd_all, mask_wr;
   logic [CH_CNT*DATA_W-1:0] in_flat;

   dacbank_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_q));
   dacbank_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
      .clk(clk), .rst_n(rst_n), .d(sync_n), .q(sync_q));
   dacbank_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdin (
      .clk(clk), .rst_n(rst_n), .d(sdin), .q(sdin_q));
   dacbank_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ldac (
      .clk(clk), .rst_n(rst_n), .d(ldac_n), .q(ldac_q));

   dacbank_fall #(.RST_VAL(1'b1), .FALLING(1'b1)) u_fall_sclk (
      .clk(clk), .rst_n(rst_n), .lvl(sclk_q), .pulse(sclk_fall));
   dacbank_fall #(.RST_VAL(1'b1), .FALLING(1'b1)) u_fall_ldac (
      .clk(clk), .rst_n(rst_n), .lvl(ldac_q), .pulse(ld_pulse));

   dacbank_shift u_shift (
      .clk(clk), .rst_n(rst_n), .sel(~sync_q), .bit_stb(sclk_fall),
      .bit_val(sdin_q), .frame_vld(frame_vld), .frame_word(frame_word));

   dacbank_decode #(.CH_CNT(CH_CNT), .DATA_W(DATA_W)) u_dec (
      .frame_vld(frame_vld), .frame_word(frame_word), .wr_sel(wr_sel),
      .wr_data(wr_data), .upd_all(upd_all), .mask_wr(mask_wr),
      .mask_data(mask_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask <= '0;
      else if (mask_wr) mask <= mask_data;
   end

   for (genvar ch = 0; ch < CH_CNT; ch++) begin : g_ch
      dacbank_chan #(.DATA_W(DATA_W)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .wr(wr_sel[ch]), .wr_data(wr_data),
         .upd_on_wr(mask[ch] | ~ldac_q),
         .upd_all(upd_all),
         .upd_pin(ld_pulse & ~mask[ch]),
         .in_val(in_flat[ch*DATA_W +: DATA_W]),
         .dac_val(dac_out[ch*DATA_W +: DATA_W]));
   end
endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk #(
   parameter int CH_CNT = 8,
   parameter int DATA_W = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     frame_vld,
   input logic [3:0]               frame_cmd,
   input logic [CH_CNT-1:0]        frame_lo,
   input logic                     ld_pulse,
   input logic [CH_CNT-1:0]        mask,
   input logic [CH_CNT*DATA_W-1:0] in_flat,
   input logic [CH_CNT*DATA_W-1:0] dac_out
);
   logic known_cmd;
   assign known_cmd = (frame_cmd == 4'b0000) || (frame_cmd == 4'b0011) || (frame_cmd == 4'b0110);

   // R4: outputs move only on a completed frame or a load-pin pulse
   p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_vld && !ld_pulse) |=> $stable(dac_out));

   // R4: pin edge gives a single-cycle pulse
   p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ld_pulse |=> !ld_pulse);

   // R5: mask takes the low frame bits on its command
   p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && frame_cmd == 4'b0110) |=> (mask == $past(frame_lo)));

   // R5: mask changes on no other event
   p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_vld && frame_cmd == 4'b0110) |=> $stable(mask));

   // R8: release-all leaves every output equal to its staging register
   p_upd_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && frame_cmd == 4'b0011) |=> (dac_out == in_flat));

   // R11: unknown commands leave all registers untouched
   p_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && !known_cmd && !ld_pulse) |=>
         ($stable(dac_out) && $stable(in_flat) && $stable(mask)));
endmodule

bind ser_dac_bank dacbank_chk #(.CH_CNT(CH_CNT), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld),
   .frame_cmd(frame_word[27:24]), .frame_lo(frame_word[CH_CNT-1:0]),
   .ld_pulse(ld_pulse), .mask(mask), .in_flat(in_flat), .dac_out(dac_out));

// File: tb/ser_dac_bank_bench.sv
module ser_dac_bank_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_BIT   = 4;
   localparam int NCH        = 8;
   localparam int DW         = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, ldac_n = 1'b1;
   logic [NCH*DW-1:0] dac_out;

   int n_chk = 0, n_fail = 0;
   bit busy = 1'b1;
   bit finished = 1'b0;
   string cur_tag = "R1";

   // behavioural reference state
   int  m_in [NCH];
   int  m_dac[NCH];
   int  m_mask = 0;
   bit  m_ldac_low = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ser_dac_bank u_ser_dac_bank (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n),
      .sdin(sdin), .ldac_n(ldac_n), .dac_out(dac_out));

   function automatic int out_of(input int ch);
      return int'(dac_out[ch*DW +: DW]);
   endfunction

   // every quiet clock: outputs against the model
   always @(negedge clk) begin
      if (!busy && !finished) begin
         for (int ch = 0; ch < NCH; ch++) begin
            n_chk++;
            if (out_of(ch) != m_dac[ch]) begin
               n_fail++;
               $display("FAIL %s model ch%0d actual %03h expected %03h", cur_tag, ch, out_of(ch), m_dac[ch]);
            end
         end
      end
   end

   task automatic check_ch(input int ch, input int exp, input string tag);
      @(negedge clk);
      n_chk++;
      if (out_of(ch) != exp) begin
         n_fail++;
         $display("FAIL %s ch%0d actual %03h expected %03h", tag, ch, out_of(ch), exp);
      end
   endtask

   task automatic model_frame(input logic [31:0] w);
      int cmd = int'(w[27:24]);
      int adr = int'(w[23:20]);
      int dat = int'(w[19:8]);
      if (cmd == 0 || cmd == 3) begin
         for (int ch = 0; ch < NCH; ch++) begin
            if (adr == ch || adr == 15) begin
               m_in[ch] = dat;
               if (m_mask[ch] || m_ldac_low) m_dac[ch] = m_in[ch];
            end
         end
         if (cmd == 3) for (int ch = 0; ch < NCH; ch++) m_dac[ch] = m_in[ch];
      end else if (cmd == 6) begin
         m_mask = int'(w[7:0]);
      end
   endtask

   task automatic send(input logic [31:0] w, input int nbits, input int extra, input string tag);
      busy = 1'b1;
      cur_tag = tag;
      sync_n = 1'b0;
      repeat (HALF_BIT) @(posedge clk);
      for (int i = 0; i < nbits + extra; i++) begin
         sdin = (i < nbits) ? w[31-i] : 1'b0;
         repeat (HALF_BIT) @(posedge clk);
         sclk = 1'b0;
         repeat (HALF_BIT) @(posedge clk);
         sclk = 1'b1;
      end
      repeat (HALF_BIT) @(posedge clk);
      sync_n = 1'b1;
      repeat (14) @(posedge clk);
      if (nbits == 32) model_frame(w);
      busy = 1'b0;
      @(posedge clk);
   endtask

   task automatic frame(input logic [3:0] top, input logic [3:0] cmd, input logic [3:0] adr,
                        input logic [11:0] dat, input logic [7:0] lo, input string tag);
      send({top, cmd, adr, dat, lo}, 32, 0, tag);
   endtask

   task automatic pin(input bit low, input string tag);
      busy = 1'b1;
      cur_tag = tag;
      ldac_n = !low;
      repeat (10) @(posedge clk);
      m_ldac_low = low;
      if (low) for (int ch = 0; ch < NCH; ch++) if (!m_mask[ch]) m_dac[ch] = m_in[ch];
      busy = 1'b0;
      @(posedge clk);
   endtask

   initial begin
      for (int ch = 0; ch < NCH; ch++) begin m_in[ch] = 0; m_dac[ch] = 0; end
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      busy = 1'b0;
      // R1: reset values
      for (int ch = 0; ch < NCH; ch++) check_ch(ch, 0, "R1");

      // R3/R4: write A while pin high, output waits for the pin edge
      frame(4'h0, 4'h0, 4'h0, 12'h123, 8'h00, "R4");
      check_ch(0, 12'h000, "R4");
      pin(1'b1, "R4");
      check_ch(0, 12'h123, "R4");
      pin(1'b0, "R4");

      // R2: top nibble ignored; R3: address 9 writes nothing
      frame(4'hA, 4'h0, 4'h2, 12'h456, 8'hFF, "R2");
      frame(4'h0, 4'h0, 4'h9, 12'h777, 8'h00, "R3");
      frame(4'h0, 4'h0, 4'h7, 12'h0F0, 8'h00, "R3");
      check_ch(2, 12'h000, "R4");
      pin(1'b1, "R3");
      check_ch(2, 12'h456, "R2");
      check_ch(7, 12'h0F0, "R3");
      check_ch(1, 12'h000, "R3");
      pin(1'b0, "R3");

      // R5: mask A and C, address and data fields junk
      frame(4'h0, 4'h6, 4'h9, 12'hFFF, 8'h05, "R5");
      check_ch(0, 12'h123, "R5");
      // R6: masked channel updates at frame end with pin high
      frame(4'h0, 4'h0, 4'h0, 12'h321, 8'h00, "R6");
      check_ch(0, 12'h321, "R6");
      frame(4'h0, 4'h0, 4'h1, 12'h654, 8'h00, "R5");
      check_ch(1, 12'h000, "R5");

      // R11: unused commands
      frame(4'h0, 4'h5, 4'h1, 12'h999, 8'hFF, "R11");
      frame(4'h0, 4'hF, 4'hF, 12'h888, 8'hFF, "R11");
      pin(1'b1, "R11");
      check_ch(1, 12'h654, "R11");
      check_ch(0, 12'h321, "R6");
      pin(1'b0, "R11");

      // R9: aborted frame for D
      send({4'h0, 4'h0, 4'h3, 12'hABC, 8'h00}, 20, 0, "R9");
      pin(1'b1, "R9");
      check_ch(3, 12'h000, "R9");
      pin(1'b0, "R9");

      // R10: 32 extra zero bits would form a write of 0 to masked A
      send({4'h0, 4'h0, 4'h4, 12'h5A5, 8'h00}, 32, 32, "R10");
      check_ch(0, 12'h321, "R10");
      pin(1'b1, "R10");
      check_ch(4, 12'h5A5, "R10");
      pin(1'b0, "R10");

      // R8: staged G then release-all with a write to F
      frame(4'h0, 4'h0, 4'h6, 12'h111, 8'h00, "R8");
      check_ch(6, 12'h000, "R8");
      frame(4'h0, 4'h3, 4'h5, 12'h0DE, 8'h00, "R8");
      check_ch(5, 12'h0DE, "R8");
      check_ch(6, 12'h111, "R8");

      // R7: pin held low, unmasked channel updates at frame end
      pin(1'b1, "R7");
      frame(4'h0, 4'h0, 4'h7, 12'h0AA, 8'h00, "R7");
      check_ch(7, 12'h0AA, "R7");
      frame(4'h0, 4'h0, 4'hF, 12'h0BC, 8'h00, "R7");
      for (int ch = 0; ch < NCH; ch++) check_ch(ch, 12'h0BC, "R7");
      pin(1'b0, "R7");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_fail++;
         $display("FAIL watchdog %s actual hung expected done", cur_tag);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule